// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block keeps the control and status state of one channel of a descriptor-driven DMA engine. Software reaches it through a 32-bit register bus, word-indexed. Status bits are never written directly. Software sends a control word: its upper half says which bits to change and its lower half gives their new values. The block then works out the channel's activity and error flags from the run, pause and wake bits that result.

The block also holds the command pointer, which is aligned to 16 bytes and locked while the channel runs. It stores three condition-select words for the descriptor sequencer and returns all of these on reads. Toward the sequencer it drives a run level, an activity level and a flush level. It also drives three one-cycle strobes: kick (start fetching), flush, and command-pointer load. In the other direction, the sequencer can set or clear the error, activity, flush, wake and branch-taken flags.

Top module: `dmaChanCsr`

## Requirements
- R1: After reset, every stored register is zero. All outputs are low and every register index reads zero.
- R2: A write to index 0 (control) changes status bit n only where mask bit 16+n is 1; the new value comes from bit n of the word. Only run (bit 15), pause (14), flush (13), wake (12) and the device field (bits 7:0) can change this way. Error (bit 11), activity (bit 10) and branch-taken (bit 8) ignore the mask.
- R3: If the merged result has wake set, activity is set. If it has run set, activity is set and error is cleared.
- R4: If the merged result has pause set, activity is cleared. This rule wins over R3.
- R5: If a control write changes run from 1 to 0, activity and error are both cleared.
- R6: A write to index 3 (command pointer) is ignored while run or activity is set. No load strobe follows it.
- R7: An accepted pointer write stores the word with bits 3:0 forced to zero. cmdLoad is high for exactly the one cycle after the write edge.
- R8: Reading index 0 returns zero. Index 1 returns the status word (bits 31:16 zero), index 3 the pointer, and indices 4, 5 and 6 the interrupt, branch and wait select words. Every other index reads zero. Writes to index 1 and to unused indices change nothing.
- R9: kickPulse is high for one cycle after a control write that leaves activity set. flushPulse is high for one cycle after a control write that leaves flush set.
- R10: Sequencer vectors seqSet/seqClr, in the bit order error(0), activity(1), flush(2), wake(3), branch-taken(4), set or clear status bits 11, 10, 13, 12 and 8. Set wins over clear. Both vectors are dropped in a cycle that carries a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write enable |
| busAddr | input | ADDR_W | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| seqSet | input | 5 | Sequencer flag set requests |
| seqClr | input | 5 | Sequencer flag clear requests |
| statusWord | output | 32 | Current status word |
| cmdPtr | output | 32 | Command pointer |
| intrSel | output | 32 | Interrupt condition select word |
| branchSel | output | 32 | Branch condition select word |
| waitSel | output | 32 | Wait condition select word |
| runFlag | output | 1 | Run bit |
| activeFlag | output | 1 | Activity bit |
| flushFlag | output | 1 | Flush bit |
| cmdLoad | output | 1 | Descriptor fetch strobe after a pointer write |
| kickPulse | output | 1 | Start strobe after a control write |
| flushPulse | output | 1 | Flush strobe after a control write |

## Verification
The assertions watch several rules on every cycle:
- the next state after any control write: pause leaves activity clear, run leaves error clear, and dropping run clears both;
- the pointer lock under run or activity;
- the alignment of loaded pointers;
- the zero read of the control index;
- the strobes agreeing with the flags;
- a sequencer set landing when no control write competes.

Only the bench's sweeps show the full masked merge across every mask and value nibble from many prior states, the set-over-clear priority over all vector pairs, and the complete read map.

// File: rtl/dmaCsrPkg.sv
package dmaCsrPkg;
  localparam int DATA_W = 32;
  localparam int STAT_W = 16;

  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_FLUSH  = 13;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;
  localparam int BIT_BT     = 8;

  localparam logic [STAT_W-1:0] CTL_WRITABLE = 16'hF0FF;

  localparam int IDX_CTL  = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_PTR  = 3;
  localparam int IDX_SEL0 = 4;
  localparam int SEL_N    = 3;

  localparam int SQ_N = 5;

  typedef struct packed {
    logic             ctlWr;
    logic             ptrWr;
    logic [SEL_N-1:0] selWr;
  } csrStrobes_t;
endpackage

// File: rtl/dmaCsrCtrl.sv
module dmaCsrCtrl
  import dmaCsrPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              statRun,
  input  logic              statActive,
  input  logic              nxtActive,
  input  logic              nxtFlush,
  output csrStrobes_t       strb,
  output logic              cmdLoad,
  output logic              kickPulse,
  output logic              flushPulse
);
  logic ptrLocked;

  assign ptrLocked  = statRun | statActive;
  assign strb.ctlWr = busWe && (busAddr == ADDR_W'(IDX_CTL));
  assign strb.ptrWr = busWe && (busAddr == ADDR_W'(IDX_PTR)) && !ptrLocked;

  for (genvar g = 0; g < SEL_N; g++) begin : gSelDec
    assign strb.selWr[g] = busWe && (busAddr == ADDR_W'(IDX_SEL0 + g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLoad    <= 1'b0;
      kickPulse  <= 1'b0;
      flushPulse <= 1'b0;
    end else begin
      cmdLoad    <= strb.ptrWr;
      kickPulse  <= strb.ctlWr && nxtActive;
      flushPulse <= strb.ctlWr && nxtFlush;
    end
  end
endmodule

// File: rtl/dmaCsrData.sv
module dmaCsrData
  import dmaCsrPkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  csrStrobes_t                   strb,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  input  logic [SQ_N-1:0]               seqSet,
  input  logic [SQ_N-1:0]               seqClr,
  output logic [DATA_W-1:0]             busRdata,
  output logic [DATA_W-1:0]             statusWord,
  output logic [DATA_W-1:0]             cmdPtr,
  output logic [SEL_N-1:0][DATA_W-1:0]  selRegs,
  output logic                          nxtActive,
  output logic                          nxtFlush
);
  localparam int unsigned SEQ_POS [SQ_N] = '{BIT_DEAD, BIT_ACTIVE, BIT_FLUSH, BIT_WAKE, BIT_BT};

  logic [STAT_W-1:0] statReg, ctlNext, seqNext, wrMask, wrVal;
  logic [DATA_W-1:0] ptrReg;

  always_comb begin
    wrMask  = busWdata[DATA_W-1:STAT_W] & CTL_WRITABLE;
    wrVal   = busWdata[STAT_W-1:0] & CTL_WRITABLE;
    ctlNext = (wrVal & wrMask) | (statReg & ~wrMask);
    if (ctlNext[BIT_WAKE]) ctlNext[BIT_ACTIVE] = 1'b1;
    if (ctlNext[BIT_RUN]) begin
      ctlNext[BIT_ACTIVE] = 1'b1;
      ctlNext[BIT_DEAD]   = 1'b0;
    end
    if (ctlNext[BIT_PAUSE]) ctlNext[BIT_ACTIVE] = 1'b0;
    if (statReg[BIT_RUN] && !ctlNext[BIT_RUN]) begin
      ctlNext[BIT_ACTIVE] = 1'b0;
      ctlNext[BIT_DEAD]   = 1'b0;
    end
  end

  always_comb begin
    seqNext = statReg;
    for (int k = 0; k < SQ_N; k++) begin
      seqNext[SEQ_POS[k]] = seqSet[k] | (statReg[SEQ_POS[k]] & ~seqClr[k]);
    end
  end

  assign nxtActive = ctlNext[BIT_ACTIVE];
  assign nxtFlush  = ctlNext[BIT_FLUSH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (strb.ctlWr) begin
      statReg <= ctlNext;
    end else begin
      statReg <= seqNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0;
    end else if (strb.ptrWr) begin
      ptrReg <= {busWdata[DATA_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
    end
  end

  for (genvar g = 0; g < SEL_N; g++) begin : gSelReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selRegs[g] <= '0;
      end else if (strb.selWr[g]) begin
        selRegs[g] <= busWdata;
      end
    end
  end

  assign statusWord = {{(DATA_W-STAT_W){1'b0}}, statReg};
  assign cmdPtr     = ptrReg;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(IDX_STAT)) busRdata = statusWord;
    if (busAddr == ADDR_W'(IDX_PTR))  busRdata = ptrReg;
    for (int k = 0; k < SEL_N; k++) begin
      if (busAddr == ADDR_W'(IDX_SEL0 + k)) busRdata = selRegs[k];
    end
  end
endmodule

// File: rtl/dmaChanCsr.sv
module dmaChanCsr
  import dmaCsrPkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [4:0]        seqSet,
  input  logic [4:0]        seqClr,
  output logic [31:0]       statusWord,
  output logic [31:0]       cmdPtr,
  output logic [31:0]       intrSel,
  output logic [31:0]       branchSel,
  output logic [31:0]       waitSel,
  output logic              runFlag,
  output logic              activeFlag,
  output logic              flushFlag,
  output logic              cmdLoad,
  output logic              kickPulse,
  output logic              flushPulse
);
  csrStrobes_t                  strb;
  logic                         nxtActive, nxtFlush;
  logic [SEL_N-1:0][DATA_W-1:0] selRegs;

  dmaCsrCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .statRun    (statusWord[BIT_RUN]),
    .statActive (statusWord[BIT_ACTIVE]),
    .nxtActive  (nxtActive),
    .nxtFlush   (nxtFlush),
    .strb       (strb),
    .cmdLoad    (cmdLoad),
    .kickPulse  (kickPulse),
    .flushPulse (flushPulse)
  );

  dmaCsrData #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .seqSet     (seqSet),
    .seqClr     (seqClr),
    .busRdata   (busRdata),
    .statusWord (statusWord),
    .cmdPtr     (cmdPtr),
    .selRegs    (selRegs),
    .nxtActive  (nxtActive),
    .nxtFlush   (nxtFlush)
  );

  assign intrSel    = selRegs[0];
  assign branchSel  = selRegs[1];
  assign waitSel    = selRegs[2];
  assign runFlag    = statusWord[BIT_RUN];
  assign activeFlag = statusWord[BIT_ACTIVE];
  assign flushFlag  = statusWord[BIT_FLUSH];
endmodule

// File: rtl/dmaChanCsrChk.sv
module dmaChanCsrChk #(
  parameter int ADDR_W     = 5,
  parameter int ALIGN_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [4:0]        seqSet,
  input logic [4:0]        seqClr,
  input logic [31:0]       statusWord,
  input logic [31:0]       cmdPtr,
  input logic              runFlag,
  input logic              activeFlag,
  input logic              flushFlag,
  input logic              cmdLoad,
  input logic              kickPulse,
  input logic              flushPulse
);
  logic ctlW, ptrW;
  assign ctlW = busWe && (busAddr == ADDR_W'(0));
  assign ptrW = busWe && (busAddr == ADDR_W'(3));

  p_pause_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlW |=> !(statusWord[14] && activeFlag));

  p_run_undead_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctlW |=> !(runFlag && statusWord[11]));

  p_run_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlW && runFlag && busWdata[31] && !busWdata[15]) |=> (!activeFlag && !statusWord[11]));

  p_ptr_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ptrW && (runFlag || activeFlag)) |=> ($stable(cmdPtr) && !cmdLoad));

  p_ptr_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |-> (cmdPtr[ALIGN_BITS-1:0] == '0));

  p_ctl_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(0)) |-> (busRdata == 32'd0));

  p_kick_active_r9: assert property (@(posedge clk) disable iff (!rstN)
    kickPulse |-> activeFlag);

  p_flush_level_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> flushFlag);

  p_seq_bt_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlW && seqSet[4]) |=> statusWord[8]);

  p_seq_dead_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlW && seqClr[0] && !seqSet[0]) |=> !statusWord[11]);
endmodule

bind dmaChanCsr dmaChanCsrChk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .seqSet     (seqSet),
  .seqClr     (seqClr),
  .statusWord (statusWord),
  .cmdPtr     (cmdPtr),
  .runFlag    (runFlag),
  .activeFlag (activeFlag),
  .flushFlag  (flushFlag),
  .cmdLoad    (cmdLoad),
  .kickPulse  (kickPulse),
  .flushPulse (flushPulse)
);

// File: tb/test_dmaChanCsr.sv
`timescale 1ns/1ps
module test_dmaChanCsr;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [4:0]    seqSet = '0;
  logic [4:0]    seqClr = '0;
  logic [31:0]   statusWord, cmdPtr, intrSel, branchSel, waitSel;
  logic          runFlag, activeFlag, flushFlag, cmdLoad, kickPulse, flushPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] mStat = '0;
  logic [31:0] mPtr = '0;
  logic [31:0] mSel [3];
  logic [31:0] lcg = 32'h1234_5678;

  dmaChanCsr #(.ADDR_W(AW), .ALIGN_BITS(4)) i_dmaChanCsr (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .seqSet(seqSet), .seqClr(seqClr), .statusWord(statusWord),
    .cmdPtr(cmdPtr), .intrSel(intrSel), .branchSel(branchSel), .waitSel(waitSel),
    .runFlag(runFlag), .activeFlag(activeFlag), .flushFlag(flushFlag),
    .cmdLoad(cmdLoad), .kickPulse(kickPulse), .flushPulse(flushPulse)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelCtl(input logic [15:0] o, input logic [31:0] w);
    logic [15:0] m, v, n;
    m = w[31:16] & 16'hF0FF;
    v = w[15:0] & 16'hF0FF;
    n = (v & m) | (o & ~m);
    if (n[12]) n[10] = 1'b1;
    if (n[15]) begin n[10] = 1'b1; n[11] = 1'b0; end
    if (n[14]) n[10] = 1'b0;
    if (o[15] && !n[15]) begin n[10] = 1'b0; n[11] = 1'b0; end
    return n;
  endfunction

  function automatic logic [15:0] modelSeq(input logic [15:0] o, input logic [4:0] s, input logic [4:0] c);
    int pos [5] = '{11, 10, 13, 12, 8};
    logic [15:0] n;
    n = o;
    for (int k = 0; k < 5; k++) n[pos[k]] = s[k] | (o[pos[k]] & ~c[k]);
    return n;
  endfunction

  // Drive at a falling edge, return at the next falling edge with inputs idle.
  task automatic step(input logic we, input int idx, input logic [31:0] d,
                      input logic [4:0] s, input logic [4:0] c);
    busWe = we; busAddr = AW'(idx); busWdata = d; seqSet = s; seqClr = c;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0; seqSet = '0; seqClr = '0;
  endtask

  task automatic ctlOp(input logic [31:0] w, input string req);
    logic [15:0] n;
    n = modelCtl(mStat, w);
    step(1'b1, 0, w, 5'h0, 5'h0);
    mStat = n;
    chk(req, statusWord, {16'h0, mStat});
    chk("R9 kick", {31'h0, kickPulse}, {31'h0, mStat[10]});
    chk("R9 flush", {31'h0, flushPulse}, {31'h0, mStat[13]});
  endtask

  task automatic seqOp(input logic [4:0] s, input logic [4:0] c);
    step(1'b0, 2, 32'h0, s, c);
    mStat = modelSeq(mStat, s, c);
    chk("R10 seq", statusWord, {16'h0, mStat});
  endtask

  task automatic readIdx(input int idx, input logic [31:0] exp);
    busAddr = AW'(idx);
    #1;
    chk("R8 read", busRdata, exp);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) mSel[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 status", statusWord, 32'h0);
    chk("R1 ptr", cmdPtr, 32'h0);
    chk("R1 sel", intrSel | branchSel | waitSel, 32'h0);
    chk("R1 flags", {26'h0, runFlag, activeFlag, flushFlag, cmdLoad, kickPulse, flushPulse}, 32'h0);
    for (int i = 0; i < 32; i++) readIdx(i, 32'h0);

    // R2-R5, R9: sweep writable nibble and mask nibble from varied prior states
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        seqOp(lcg[4:0], lcg[9:5]);
        ctlOp({4'(b), 4'hF, 8'(lcg[17:10]), 4'(a), 4'h0, 8'(lcg[25:18])}, "R2 merge");
        ctlOp({4'hF, 12'h0, 4'(a ^ b), 12'h0}, "R3 derive");
      end
    end

    // R4 precedence: run and pause together leave activity clear
    ctlOp({16'hF000, 16'hD000}, "R4 pause wins");
    chk("R4 active", {31'h0, activeFlag}, 32'h0);
    // R5: run 1->0 clears activity and error
    ctlOp({16'hF000, 16'h8000}, "R5 run on");
    seqOp(5'b00001, 5'h0);
    ctlOp({16'h8000, 16'h0000}, "R5 run off");
    chk("R5 dead", {31'h0, statusWord[11]}, 32'h0);
    // R2: mask bits over error/activity/branch-taken have no effect
    seqOp(5'b10011, 5'h0);
    ctlOp({16'h0D00, 16'h0000}, "R2 locked bits");

    // R10: set/clear matrix from three base states
    for (int bi = 0; bi < 3; bi++) begin
      logic [4:0] base;
      base = (bi == 0) ? 5'h00 : (bi == 1) ? 5'h1F : 5'h15;
      for (int s = 0; s < 32; s++) begin
        for (int c = 0; c < 32; c++) begin
          seqOp(base, ~base);
          seqOp(5'(s), 5'(c));
        end
      end
    end
    // R10: requests dropped on a control-write cycle
    seqOp(5'h0, 5'h1F);
    step(1'b1, 0, 32'h0, 5'b10000, 5'h0);
    chk("R10 drop", statusWord, {16'h0, mStat});

    // R6/R7: pointer guard and alignment
    ctlOp({16'hF000, 16'h0000}, "R6 idle");
    seqOp(5'h0, 5'h1F);
    step(1'b1, 3, 32'h1234_567B, 5'h0, 5'h0);
    mPtr = 32'h1234_5670;
    chk("R7 ptr", cmdPtr, mPtr);
    chk("R7 load", {31'h0, cmdLoad}, 32'h1);
    step(1'b0, 2, 32'h0, 5'h0, 5'h0);
    chk("R7 load once", {31'h0, cmdLoad}, 32'h0);
    seqOp(5'b00010, 5'h0);
    step(1'b1, 3, 32'hDEAD_BEE0, 5'h0, 5'h0);
    chk("R6 active lock", cmdPtr, mPtr);
    chk("R6 no load", {31'h0, cmdLoad}, 32'h0);
    seqOp(5'h0, 5'b00010);
    ctlOp({16'h8000, 16'h8000}, "R6 run");
    seqOp(5'h0, 5'b00010);
    step(1'b1, 3, 32'hCAFE_0000, 5'h0, 5'h0);
    chk("R6 run lock", cmdPtr, mPtr);
    chk("R6 no load run", {31'h0, cmdLoad}, 32'h0);
    ctlOp({16'h8000, 16'h0000}, "R6 stop");
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 3, 32'h0000_1000 * (i + 1) + 32'(i * 5 + 1), 5'h0, 5'h0);
      mPtr = 32'h0000_1000 * (i + 1) + 32'((i * 5 + 1) & 32'hFFF0);
      chk("R7 align", cmdPtr, mPtr);
    end

    // R8: write every index except control, then read back the map
    for (int i = 1; i < 32; i++) begin
      step(1'b1, i, 32'hA5A5_0000 + 32'(i) * 32'h111, 5'h0, 5'h0);
      if (i == 3) mPtr = (32'hA5A5_0000 + 32'(i) * 32'h111) & 32'hFFFF_FFF0;
      if (i >= 4 && i <= 6) mSel[i-4] = 32'hA5A5_0000 + 32'(i) * 32'h111;
    end
    ctlOp({16'h00FF, 16'h005A}, "R8 devfield");
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      e = 32'h0;
      if (i == 1) e = {16'h0, mStat};
      if (i == 3) e = mPtr;
      if (i >= 4 && i <= 6) e = mSel[i-4];
      readIdx(i, e);
    end
    chk("R8 intr", intrSel, mSel[0]);
    chk("R8 branch", branchSel, mSel[1]);
    chk("R8 wait", waitSel, mSel[2]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule